// File: doc/BRIEF.md
# Stepper Motion Profile Generator

This block turns a stream of motion segments into step and direction pulses for an external stepper driver. Every segment carries an initial speed, a constant acceleration, a step budget and a driver mode value. A slow internal tick is derived from the system clock. On each tick the block adds the current speed to a fractional position accumulator, then adds the acceleration to the speed. Each time the position crosses a whole-step boundary, upward or downward, one step pulse goes out.

Segments are taken from an external show-ahead queue, whose head is presented on the word inputs together with a valid flag. A segment is consumed with a one-clock pop. Nothing starts until a run strobe arrives. The segments then run back to back. When a segment's last step is issued and the queue still holds a segment, that segment is loaded at the same clock edge. When the queue is empty at that point, speed and acceleration drop to zero, the mode output keeps its value and the idle flag rises.

Top module: `step_profile_gen`

## Requirements
- R1: Accumulation happens only on an internal tick, which occurs once every TICK_DIV system clocks (TICK_DIV >= 2). A constant speed command c, counted in units of 2^-RATE_RES steps per tick, gives step pulses spaced 2^RATE_RES/c ticks apart when that ratio is an integer.
- R2: The speed command is left-aligned into a speed register with ACCEL_RES fractional bits. On every tick the position gains the speed held before that tick, and the speed then gains the acceleration (ACCEL_RES fractional bits). With initial phase p, a step therefore falls on tick n exactly when floor((p + R0·n + A·n(n−1)/2) / 2^ACCUM_RES) changes.
- R3: Each boundary crossing produces a step_o pulse that is high for exactly one clock. step_o is never high on two consecutive clocks.
- R4: dir_o is the sign of the speed used on the latest tick: 1 for negative, 0 otherwise. Every step caused by a downward crossing is seen with dir_o = 1, and every step caused by an upward crossing is seen with dir_o = 0.
- R5: A count field of N yields N+1 steps. A count of 0 yields a single step.
- R6: On a segment's final step, a waiting segment is popped (word_pop_o high for one clock) and loaded at that same edge. done_o stays low across the boundary, and the position keeps its fractional phase.
- R7: mode_o takes the segment's mode value on the clock after it is loaded. mode_o holds that value after the queue runs empty.
- R8: When the final step occurs with an empty queue, speed and acceleration become zero. No further steps follow, and done_o goes high.
- R9: While done_o is high and no run strobe is given, nothing is popped and no step occurs. A run strobe with an empty queue leaves done_o high.
- R10: After reset, step_o = 0, dir_o = 0, mode_o = 0, done_o = 1 and word_pop_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | One-clock strobe that starts execution of queued segments |
| word_valid_i | input | 1 | Queue head holds a segment |
| word_rate_i | input | 1+RATE_RES-RATE_SCALE | Signed initial speed of the head segment |
| word_accel_i | input | 1+ACCEL_RES-ACCEL_SCALE | Signed acceleration of the head segment |
| word_count_i | input | COUNT_W | Number of steps minus one |
| word_mode_i | input | MODE_W | Driver mode value of the head segment |
| word_pop_o | output | 1 | Consumes the queue head |
| step_o | output | 1 | Step pulse to the driver |
| dir_o | output | 1 | Direction to the driver, 1 for negative motion |
| mode_o | output | MODE_W | Driver mode of the active or most recent segment |
| done_o | output | 1 | No segment is executing |

## Verification
The bench builds the block with TICK_DIV = 3, a 4-bit speed command with 4 fractional bits, and a 5-bit acceleration and 8-bit position accumulator, both with 8 fractional bits. With these values a constant speed of one quarter step per tick, an accelerating ramp, negative motion with downward crossings, and a three-segment chain that changes mode and reverses direction each complete within a few hundred clocks. Expected step spacing and direction are computed from the closed-form position sum. The fractional phase is carried from one test to the next, so that phase carry-over across segment loads and idle periods is exercised as well.

// File: rtl/stp_pkg.sv
package stp_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/stp_tick_div.sv
module stp_tick_div #(
  parameter int TICK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = $clog2(TICK_DIV);
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/stp_accum.sv
module stp_accum #(
  parameter int RATE_SCALE  = 1,
  parameter int RATE_RES    = 4,
  parameter int ACCEL_SCALE = 4,
  parameter int ACCEL_RES   = 8,
  parameter int ACCUM_RES   = 8,
  parameter int HAS_DIR     = 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            tick_i,
  input  logic                            load_i,
  input  logic                            clear_i,
  input  logic [RATE_RES-RATE_SCALE:0]    rate_cmd_i,
  input  logic [ACCEL_RES-ACCEL_SCALE:0]  accel_i,
  output logic                            wrap_o,
  output logic                            step_o,
  output logic                            dir_o
);
  localparam int RATE_W = 1 + ACCEL_RES - RATE_SCALE;
  localparam int ACC_W  = 1 + ACCEL_RES - ACCEL_SCALE;
  localparam int CMD_SH = ACCEL_RES - RATE_RES;
  localparam int ANG_SH = ACCEL_RES - ACCUM_RES;
  localparam int SUM_W  = ACCUM_RES + 2;

  logic signed [RATE_W-1:0] rate_q, rate_ld, rate_ang;
  logic signed [ACC_W-1:0]  accel_q;
  logic [ACCUM_RES-1:0]     phase_q;
  logic signed [SUM_W-1:0]  sum;
  logic                     wrap_up, wrap_dn, step_q;

  always_comb begin
    rate_ld  = {rate_cmd_i, {CMD_SH{1'b0}}};
    rate_ang = rate_q >>> ANG_SH;
    sum      = $signed({2'b00, phase_q}) + SUM_W'(rate_ang);
    wrap_dn  = sum[SUM_W-1];
    wrap_up  = ~sum[SUM_W-1] & sum[SUM_W-2];
  end

  assign wrap_o = tick_i & (wrap_up | wrap_dn);

  // speed/acceleration registers: load beats clear beats integrate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q  <= '0;
      accel_q <= '0;
    end else if (load_i) begin
      rate_q  <= rate_ld;
      accel_q <= accel_i;
    end else if (clear_i) begin
      rate_q  <= '0;
      accel_q <= '0;
    end else if (tick_i) begin
      rate_q  <= rate_q + RATE_W'(accel_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      step_q  <= 1'b0;
    end else begin
      step_q <= wrap_o;
      if (tick_i) phase_q <= sum[ACCUM_RES-1:0];
    end
  end

  assign step_o = step_q;

  generate
    if (HAS_DIR != 0) begin : g_dir
      logic dir_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     dir_q <= 1'b0;
        else if (tick_i) dir_q <= rate_q[RATE_W-1];
      end
      assign dir_o = dir_q;
    end else begin : g_nodir
      assign dir_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/stp_sequencer.sv
module stp_sequencer
  import stp_pkg::*;
#(
  parameter int COUNT_W = 8,
  parameter int MODE_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               wrap_i,
  input  logic               word_valid_i,
  input  logic [COUNT_W-1:0] word_count_i,
  input  logic [MODE_W-1:0]  word_mode_i,
  output logic               load_o,
  output logic               clear_o,
  output logic [MODE_W-1:0]  mode_o,
  output logic               done_o
);
  seq_state_e         state_q;
  logic [COUNT_W-1:0] remain_q;
  logic [MODE_W-1:0]  mode_q;
  logic               last_step, start;

  always_comb begin
    start     = (state_q == SEQ_IDLE) & run_i & word_valid_i;
    last_step = (state_q == SEQ_RUN) & wrap_i & (remain_q == '0);
    load_o    = start | (last_step & word_valid_i);
    clear_o   = last_step & ~word_valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      remain_q <= '0;
      mode_q   <= '0;
    end else if (load_o) begin
      state_q  <= SEQ_RUN;
      remain_q <= word_count_i;
      mode_q   <= word_mode_i;
    end else if (clear_o) begin
      state_q  <= SEQ_IDLE;
    end else if ((state_q == SEQ_RUN) && wrap_i) begin
      remain_q <= remain_q - COUNT_W'(1);
    end
  end

  assign mode_o = mode_q;
  assign done_o = (state_q == SEQ_IDLE);
endmodule

// File: rtl/step_profile_gen.sv
module step_profile_gen #(
  parameter int TICK_DIV    = 4,
  parameter int RATE_SCALE  = 1,
  parameter int RATE_RES    = 4,
  parameter int ACCEL_SCALE = 4,
  parameter int ACCEL_RES   = 8,
  parameter int ACCUM_RES   = ACCEL_RES,
  parameter int COUNT_W     = 8,
  parameter int MODE_W      = 2,
  parameter int HAS_DIR     = 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            run_i,
  input  logic                            word_valid_i,
  input  logic [RATE_RES-RATE_SCALE:0]    word_rate_i,
  input  logic [ACCEL_RES-ACCEL_SCALE:0]  word_accel_i,
  input  logic [COUNT_W-1:0]              word_count_i,
  input  logic [MODE_W-1:0]               word_mode_i,
  output logic                            word_pop_o,
  output logic                            step_o,
  output logic                            dir_o,
  output logic [MODE_W-1:0]               mode_o,
  output logic                            done_o
);
  logic tick, wrap, load, clear;

  stp_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  stp_accum #(
    .RATE_SCALE  (RATE_SCALE),
    .RATE_RES    (RATE_RES),
    .ACCEL_SCALE (ACCEL_SCALE),
    .ACCEL_RES   (ACCEL_RES),
    .ACCUM_RES   (ACCUM_RES),
    .HAS_DIR     (HAS_DIR)
  ) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (load),
    .clear_i    (clear),
    .rate_cmd_i (word_rate_i),
    .accel_i    (word_accel_i),
    .wrap_o     (wrap),
    .step_o     (step_o),
    .dir_o      (dir_o)
  );

  stp_sequencer #(.COUNT_W(COUNT_W), .MODE_W(MODE_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_i),
    .wrap_i       (wrap),
    .word_valid_i (word_valid_i),
    .word_count_i (word_count_i),
    .word_mode_i  (word_mode_i),
    .load_o       (load),
    .clear_o      (clear),
    .mode_o       (mode_o),
    .done_o       (done_o)
  );

  assign word_pop_o = load;
endmodule

// File: rtl/stp_checker.sv
module stp_checker #(
  parameter int TICK_DIV = 4,
  parameter int MODE_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              run_i,
  input logic              word_valid_i,
  input logic              pop_i,
  input logic              step_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              done_i
);
  int unsigned gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gap_q <= 0;
    else if (tick_i) gap_q <= 0;
    else             gap_q <= gap_q + 1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> (gap_q == TICK_DIV - 1)); // R1

  AST_TICK_NOT_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q < TICK_DIV); // R1

  AST_STEP_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> !step_i); // R3

  AST_POP_NEEDS_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> word_valid_i); // R6

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_i |=> $stable(mode_i)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && $past(done_i)) |-> !step_i); // R8

  AST_NO_POP_WITHOUT_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !run_i) |-> !pop_i); // R9

  AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !run_i) |=> done_i); // R9
endmodule

bind step_profile_gen stp_checker #(.TICK_DIV(TICK_DIV), .MODE_W(MODE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick),
  .run_i        (run_i),
  .word_valid_i (word_valid_i),
  .pop_i        (word_pop_o),
  .step_i       (step_o),
  .mode_i       (mode_o),
  .done_i       (done_o)
);

// File: tb/test_step_profile_gen.sv
module test_step_profile_gen;
  localparam int TD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  always #2 clk = ~clk;

  logic [3:0] q_rate [16];
  logic [4:0] q_acc  [16];
  logic [7:0] q_cnt  [16];
  logic [1:0] q_mode [16];
  int head = 0;
  int tail = 0;

  logic       valid, pop, step, dir, done;
  logic [1:0] mode;
  assign valid = (head != tail);

  step_profile_gen #(
    .TICK_DIV(TD), .RATE_SCALE(1), .RATE_RES(4), .ACCEL_SCALE(4),
    .ACCEL_RES(8), .ACCUM_RES(8), .COUNT_W(8), .MODE_W(2), .HAS_DIR(1)
  ) i_step_profile_gen (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .word_valid_i(valid),
    .word_rate_i(q_rate[head % 16]), .word_accel_i(q_acc[head % 16]),
    .word_count_i(q_cnt[head % 16]), .word_mode_i(q_mode[head % 16]),
    .word_pop_o(pop), .step_o(step), .dir_o(dir), .mode_o(mode), .done_o(done)
  );

  always @(posedge clk) if (pop) head <= head + 1;

  // monitor
  int cyc = 0, nst = 0, npop = 0, nrise = 0, dbl = 0;
  int st_time [256];
  logic st_dir [256];
  logic [1:0] st_mode [256];
  logic prev_step = 1'b0, prev_done = 1'b1;
  int n_tests = 0, n_fail = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (step) begin
      st_time[nst] = cyc;
      st_dir[nst]  = dir;
      st_mode[nst] = mode;
      nst = nst + 1;
      if (prev_step) dbl = dbl + 1;
    end
    prev_step = step;
    if (pop) npop = npop + 1;
    if (done && !prev_done) nrise = nrise + 1;
    prev_done = done;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: got %0d cycles expected at most 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    n_tests = n_tests + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // reference from the closed-form position sum
  int m_phase = 0;
  int e_tick [256];
  bit e_dir  [256];
  int e_mode [256];
  int e_n = 0, t_off = 0, base = 0;

  task automatic model_start();
    e_n = 0; t_off = 0; base = nst;
  endtask

  task automatic model_word(input int rc, input int a, input int cnt, input int md);
    int r0 = rc * 16;
    int kprev = 0;
    int acc = m_phase;
    int got = 0;
    int n = 0;
    int k;
    while (got < cnt + 1 && n < 4000) begin
      n = n + 1;
      acc = m_phase + r0 * n + (a * n * (n - 1)) / 2;
      k = acc >>> 8;
      if (k != kprev) begin
        e_tick[e_n] = t_off + n;
        e_dir[e_n]  = (k < kprev);
        e_mode[e_n] = (got == 0) ? md : -1;
        e_n = e_n + 1;
        got = got + 1;
        kprev = k;
      end
    end
    t_off = t_off + n;
    m_phase = acc & 255;
  endtask

  task automatic push(input int rc, input int a, input int cnt, input int md);
    q_rate[tail % 16] = rc[3:0];
    q_acc[tail % 16]  = a[4:0];
    q_cnt[tail % 16]  = cnt[7:0];
    q_mode[tail % 16] = md[1:0];
    tail = tail + 1;
  endtask

  task automatic strobe_run();
    @(negedge clk) run = 1'b1;
    @(negedge clk) run = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (!done && k < 20000) begin
      @(negedge clk);
      k = k + 1;
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic compare_steps(input string tag_iv);
    check(nst - base == e_n, "R5 step count", nst - base, e_n);
    for (int i = 0; i < e_n && i < nst - base; i++) begin
      check(st_dir[base + i] == e_dir[i], "R4 direction at step", st_dir[base + i], e_dir[i]);
      if (i > 0)
        check(st_time[base + i] - st_time[base + i - 1] == (e_tick[i] - e_tick[i - 1]) * TD,
              tag_iv, st_time[base + i] - st_time[base + i - 1], (e_tick[i] - e_tick[i - 1]) * TD);
      if (e_mode[i] >= 0)
        check(st_mode[base + i] == e_mode[i][1:0], "R7 mode at first step", st_mode[base + i], e_mode[i]);
    end
    check(dbl == 0, "R3 step high on adjacent clocks", dbl, 0);
  endtask

  task automatic t_reset();
    check(step == 1'b0, "R10 step after reset", step, 0);
    check(dir == 1'b0, "R10 dir after reset", dir, 0);
    check(mode == 2'd0, "R10 mode after reset", mode, 0);
    check(done == 1'b1, "R10 done after reset", done, 1);
    check(pop == 1'b0, "R10 pop after reset", pop, 0);
  endtask

  task automatic t_gate();
    int p0, s0;
    p0 = npop; s0 = nst;
    strobe_run();
    repeat (20) @(negedge clk);
    check(done == 1'b1, "R9 run with empty queue keeps done", done, 1);
    check(npop == p0, "R9 no pop on empty queue", npop - p0, 0);
    push(4, 0, 3, 1);
    repeat (60) @(negedge clk);
    check(npop == p0, "R9 no pop before run", npop - p0, 0);
    check(nst == s0, "R9 no step before run", nst - s0, 0);
    check(done == 1'b1, "R9 done before run", done, 1);
  endtask

  task automatic t_const_rate();
    model_start();
    model_word(4, 0, 3, 1);
    strobe_run();
    wait_idle();
    compare_steps("R1 constant-rate step spacing");
    check(done == 1'b1, "R8 done after last step", done, 1);
    check(mode == 2'd1, "R7 mode holds after empty", mode, 1);
  endtask

  task automatic t_accel();
    push(0, 4, 3, 2);
    model_start();
    model_word(0, 4, 3, 2);
    strobe_run();
    wait_idle();
    compare_steps("R2 accelerating step spacing");
  endtask

  task automatic t_negative();
    push(-4, 0, 2, 3);
    model_start();
    model_word(-4, 0, 2, 3);
    strobe_run();
    wait_idle();
    compare_steps("R4 negative-rate step spacing");
    check(dir == 1'b0, "R4 dir returns low at zero speed", dir, 0);
  endtask

  task automatic t_single();
    push(7, 0, 0, 0);
    model_start();
    model_word(7, 0, 0, 0);
    strobe_run();
    wait_idle();
    compare_steps("R5 single-step spacing");
    check(nst - base == 1, "R5 count zero gives one step", nst - base, 1);
  endtask

  task automatic t_chain();
    int p0, r0;
    p0 = npop; r0 = nrise;
    push(5, 0, 2, 3);
    push(3, 2, 2, 1);
    push(-6, 1, 1, 2);
    model_start();
    model_word(5, 0, 2, 3);
    model_word(3, 2, 2, 1);
    model_word(-6, 1, 1, 2);
    strobe_run();
    wait_idle();
    compare_steps("R6 chained step spacing with carried phase");
    check(npop - p0 == 3, "R6 pops for three segments", npop - p0, 3);
    check(nrise - r0 == 1, "R6 done rises once per chain", nrise - r0, 1);
    check(mode == 2'd2, "R7 mode holds last segment value", mode, 2);
  endtask

  task automatic t_quiet();
    int s0;
    s0 = nst;
    repeat (150) @(negedge clk);
    check(nst == s0, "R8 no steps once queue empty", nst - s0, 0);
    check(done == 1'b1, "R8 done stays high", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_gate();
    t_const_rate();
    t_accel();
    t_negative();
    t_single();
    t_chain();
    t_quiet();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule